// File: doc/BRIEF.md
# Hierarchical Array Multiplier

This block multiplies two unsigned operands and returns their full-width product. It has no clock, no state and no flags. The default operands are 16 bits wide and the product is 32 bits wide. A multiply unit that must not depend on a synthesis tool's own multiplier mapping can use it directly.

The unit is built by recursion. At every level the operands are split into high and low halves. Four half-width multipliers form the cross products, and two adders merge them as (HH << n) + (HL << n/2) + (LH << n/2) + LL, where n is the operand width at that level. The recursion stops at a leaf array multiplier. The leaf forms its partial products with AND gates and reduces them row by row through chains of half and full adders, in the same way as long multiplication by hand. With the default widths this gives 16x16 from four 8x8 units, and each 8x8 unit comes from four 4x4 leaf arrays.

A parameter picks the merge adder. It can be a carry ripple chain or a parallel-prefix carry-lookahead adder, which is shorter on the critical path. Widths are checked at elaboration.

Top module: `hmul_array`

## Requirements
- R1: `product` equals the exact unsigned product of `op_a` and `op_b` for every operand pair, with no bits lost, including pairs whose cross products carry across the half-width boundary.
- R2: If either operand is zero, `product` is zero.
- R3: If one operand is 1, `product` equals the other operand zero-extended to the product width.
- R4: With both operands all ones (0xFFFF), `product` is 0xFFFE0001.
- R5: Bit 0 of `product` is the AND of bit 0 of the two operands.
- R6: Swapping the two operands does not change `product`.
- R7: If `op_b` is 2^k, `product` equals `op_a` shifted left by k bit positions, for every k from 0 to 15.
- R8: The ripple variant (`ADDER` = `ADD_RIPPLE`) and the prefix variant (`ADDER` = `ADD_PREFIX`) give the same `product` for the same operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | OP_W (16) | Unsigned multiplicand |
| op_b | input | OP_W (16) | Unsigned multiplier |
| product | output | 2*OP_W (32) | Unsigned full-width product |

## Verification
The operand patterns are chosen to reach separate parts of the tree. Zero and unit operands show whether any cross product leaks into the result. Single-bit multipliers walk a one across all four quadrants, so a merge shifted by the wrong amount shows up as a misplaced copy of `op_a`. All-ones operands and the complementary quadrant masks (0xFF00 against 0x00FF, and similar) cause the longest carry runs in every merge adder and in every leaf row. Swapped operand pairs catch an HL/LH term that is wired to the wrong slot. Random pairs then cover general values, and both adder variants are compared on every vector.

// File: rtl/hmul_pkg.sv
package hmul_pkg;

   typedef enum logic {
      ADD_RIPPLE = 1'b0,
      ADD_PREFIX = 1'b1
   } adder_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int clog2i(input int v);
      int r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/hmul_cells.sv
module hmul_ha (
   input  logic x,
   input  logic y,
   output logic s,
   output logic c
);
   assign s = x ^ y;
   assign c = x & y;
endmodule

module hmul_fa (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   logic t;
   assign t  = x ^ y;
   assign s  = t ^ ci;
   assign co = (x & y) | (t & ci);
endmodule

// File: rtl/hmul_leaf.sv
module hmul_leaf #(
   parameter int N = 4
) (
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic [2*N-1:0] p
);
   logic [N-1:0] pp   [N];
   logic [N-1:0] upr  [1:N-1];
   logic [N-1:0] rsum [1:N-1];
   logic [N:1]   rcry [1:N-1];

   genvar gi, gj;
   generate
      for (gi = 0; gi < N; gi++) begin : g_pp_row
         for (gj = 0; gj < N; gj++) begin : g_pp_col
            assign pp[gi][gj] = a[gj] & b[gi];
         end
      end

      assign p[0]   = pp[0][0];
      assign upr[1] = {1'b0, pp[0][N-1:1]};

      for (gi = 1; gi < N; gi++) begin : g_row
         for (gj = 0; gj < N; gj++) begin : g_cell
            if (gj == 0) begin : g_h
               hmul_ha u_ha (
                  .x(upr[gi][0]), .y(pp[gi][0]),
                  .s(rsum[gi][0]), .c(rcry[gi][1])
               );
            end else begin : g_f
               hmul_fa u_fa (
                  .x(upr[gi][gj]), .y(pp[gi][gj]), .ci(rcry[gi][gj]),
                  .s(rsum[gi][gj]), .co(rcry[gi][gj+1])
               );
            end
         end
         assign p[gi] = rsum[gi][0];
         if (gi < N - 1) begin : g_next
            assign upr[gi+1] = {rcry[gi][N], rsum[gi][N-1:1]};
         end else begin : g_last
            assign p[2*N-1:N] = {rcry[gi][N], rsum[gi][N-1:1]};
         end
      end
   endgenerate
endmodule

// File: rtl/hmul_add.sv
module hmul_add #(
   parameter int              W     = 32,
   parameter hmul_pkg::adder_e ADDER = hmul_pkg::ADD_PREFIX
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] s
);
   localparam int CW = W - 1;
   localparam int LV = hmul_pkg::clog2i(CW);

   logic [W-1:0] prop;
   logic [W-1:0] cin;

   assign prop   = x ^ y;
   assign cin[0] = 1'b0;
   assign s      = prop ^ cin;

   generate
      if (ADDER == hmul_pkg::ADD_RIPPLE) begin : g_ripple
         genvar i;
         for (i = 0; i < CW; i++) begin : g_bit
            assign cin[i+1] = (x[i] & y[i]) | (prop[i] & cin[i]);
         end
      end else begin : g_prefix
         logic [CW-1:0] gg [LV+1];
         logic [CW-1:0] pg [LV+1];
         assign gg[0] = x[CW-1:0] & y[CW-1:0];
         assign pg[0] = prop[CW-1:0];
         genvar k, i;
         for (k = 0; k < LV; k++) begin : g_lvl
            for (i = 0; i < CW; i++) begin : g_bit
               if (i >= (1 << k)) begin : g_mrg
                  assign gg[k+1][i] = gg[k][i] | (pg[k][i] & gg[k][i-(1<<k)]);
                  assign pg[k+1][i] = pg[k][i] & pg[k][i-(1<<k)];
               end else begin : g_pas
                  assign gg[k+1][i] = gg[k][i];
                  assign pg[k+1][i] = pg[k][i];
               end
            end
         end
         assign cin[W-1:1] = gg[LV];
      end
   endgenerate
endmodule

// File: rtl/hmul_node.sv
module hmul_node #(
   parameter int               W     = 16,
   parameter int               LEAF  = 4,
   parameter hmul_pkg::adder_e ADDER = hmul_pkg::ADD_PREFIX
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);
   localparam int H = W / 2;

   generate
      if (W == LEAF) begin : g_leaf
         hmul_leaf #(.N(W)) u_leaf (.a(a), .b(b), .p(p));
      end else begin : g_split
         logic [W-1:0]   hh, hl, lh, ll;
         logic [2*W-1:0] mid_hl, mid_lh, part;

         hmul_node #(.W(H), .LEAF(LEAF), .ADDER(ADDER)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(hh));
         hmul_node #(.W(H), .LEAF(LEAF), .ADDER(ADDER)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(hl));
         hmul_node #(.W(H), .LEAF(LEAF), .ADDER(ADDER)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(lh));
         hmul_node #(.W(H), .LEAF(LEAF), .ADDER(ADDER)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(ll));

         assign mid_hl = {{H{1'b0}}, hl, {H{1'b0}}};
         assign mid_lh = {{H{1'b0}}, lh, {H{1'b0}}};

         hmul_add #(.W(2*W), .ADDER(ADDER)) u_add0 (.x({hh, ll}), .y(mid_hl), .s(part));
         hmul_add #(.W(2*W), .ADDER(ADDER)) u_add1 (.x(part),     .y(mid_lh), .s(p));
      end
   endgenerate
endmodule

// File: rtl/hmul_array.sv
module hmul_array #(
   parameter int               OP_W   = 16,
   parameter int               LEAF_W = 4,
   parameter hmul_pkg::adder_e ADDER  = hmul_pkg::ADD_PREFIX
) (
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   output logic [2*OP_W-1:0] product
);
   localparam int RATIO = OP_W / LEAF_W;

   generate
      if (LEAF_W < 2 || (OP_W % LEAF_W) != 0 || !hmul_pkg::is_pow2(RATIO)) begin : g_bad_cfg
         $error("hmul_array: OP_W must be LEAF_W times a power of two, LEAF_W >= 2");
      end
   endgenerate

   hmul_node #(.W(OP_W), .LEAF(LEAF_W), .ADDER(ADDER)) u_root (
      .a(op_a), .b(op_b), .p(product)
   );
endmodule

// File: rtl/hmul_array_chk.sv
module hmul_array_chk #(
   parameter int OP_W = 16
) (
   input logic [OP_W-1:0]   op_a,
   input logic [OP_W-1:0]   op_b,
   input logic [2*OP_W-1:0] product
);
   localparam logic [OP_W-1:0]   ONES = {OP_W{1'b1}};
   localparam logic [2*OP_W-1:0] SQ   = {{(OP_W-1){1'b1}}, 1'b0, {(OP_W-1){1'b0}}, 1'b1};

   always_comb begin
      // R2
      zero_operand_chk: assert (!((op_a == '0) || (op_b == '0)) || (product == '0));
      // R3
      unit_operand_chk: assert (!(op_b == OP_W'(1)) || (product == {{OP_W{1'b0}}, op_a}));
      // R3
      unit_operand_a_chk: assert (!(op_a == OP_W'(1)) || (product == {{OP_W{1'b0}}, op_b}));
      // R4
      all_ones_chk: assert (!((op_a == ONES) && (op_b == ONES)) || (product == SQ));
      // R5
      lsb_chk: assert (product[0] == (op_a[0] & op_b[0]));
   end
endmodule

bind hmul_array hmul_array_chk #(.OP_W(OP_W)) u_chk (
   .op_a(op_a), .op_b(op_b), .product(product)
);

// File: tb/hmul_array_tb.sv
module hmul_array_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   typedef struct {
      logic [W-1:0]   a;
      logic [W-1:0]   b;
      logic [2*W-1:0] exp;
      string          tag;
   } item_t;

   logic clk = 1'b0;
   logic [W-1:0]   op_a = '0;
   logic [W-1:0]   op_b = '0;
   logic [2*W-1:0] prod_pfx, prod_rpl;
   item_t          sb_q[$];
   int             checks = 0;
   int             errors = 0;
   bit             done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hmul_array #(.OP_W(W), .LEAF_W(4), .ADDER(hmul_pkg::ADD_PREFIX)) u_dut (
      .op_a(op_a), .op_b(op_b), .product(prod_pfx));
   hmul_array #(.OP_W(W), .LEAF_W(4), .ADDER(hmul_pkg::ADD_RIPPLE)) u_dut_rpl (
      .op_a(op_a), .op_b(op_b), .product(prod_rpl));

   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      op_a   = a;
      op_b   = b;
      it.a   = a;
      it.b   = b;
      it.exp = 32'(a) * 32'(b);
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   // monitor: compares at the falling edge after each drive
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (prod_pfx !== it.exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", it.tag, it.a, it.b, prod_pfx, it.exp);
         end
         checks++;
         if (prod_rpl !== it.exp) begin
            errors++;
            $display("FAIL R8 (%s) ripple a=%h b=%h actual=%h expected=%h", it.tag, it.a, it.b, prod_rpl, it.exp);
         end
      end
   end

   initial begin
      // idle state with zero operands (R2)
      drive(16'h0000, 16'h0000, "R2 idle");
      drive(16'h0000, 16'hBEEF, "R2");
      drive(16'hFFFF, 16'h0000, "R2");
      drive(16'h0001, 16'hA5C3, "R3");
      drive(16'hFFFF, 16'h0001, "R3");
      drive(16'hFFFF, 16'hFFFF, "R4");
      drive(16'h8001, 16'h0003, "R5");
      drive(16'h7FFF, 16'h8000, "R5");
      drive(16'hFF00, 16'h00FF, "R1 quadrant");
      drive(16'h00FF, 16'hFF00, "R1 quadrant");
      drive(16'hF0F0, 16'h0F0F, "R1 quadrant");
      drive(16'h8000, 16'h8000, "R1 top");
      drive(16'h1234, 16'hFEDC, "R6");
      drive(16'hFEDC, 16'h1234, "R6");
      drive(16'h00F1, 16'hC000, "R6");
      drive(16'hC000, 16'h00F1, "R6");
      for (int k = 0; k < W; k++) begin
         drive(16'hB3C5, 16'(1) << k, "R7");
         drive(16'hFFFF, 16'(1) << k, "R7");
      end
      for (int n = 0; n < 300; n++) begin
         drive(16'($urandom()), 16'($urandom()), "R1 random");
      end
      while (sb_q.size() > 0) @(posedge clk);
      @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule